// File: doc/BRIEF.md
# Nibble Reverse Transmitter

This block sends bytes from the peripheral back to the host over four status pins, four bits at a time. A CPU or DMA engine writes one byte into a holding register. The block sends the lower four bits first and the upper four bits second. Each half is paced by the host: the host pulls its request line low, and the block drives the four status pins. After a fixed setup delay the block pulls its acknowledge line low. It holds that state until the host lets the request line go high again.

The block works only while the mode input selects nibble transfers (value 4). Firmware does the link negotiation before it selects the mode. A flag shows when the holding register is empty. It can be used as a DMA request or read as a ready indication by the writer.

Top module: `nib_rev_tx`

## Requirements
- R1: After reset, `periph_ack_n` is 1, all four status pins are 0 and `buf_empty` is 1.
- R2: A write (`wr_en` high) is accepted only when `mode` equals 4 and `buf_empty` is 1. On acceptance the byte is stored and `buf_empty` reads 0 from the next cycle.
- R3: A write while `buf_empty` is 0, or while `mode` is not 4, has no effect: the held byte and the flag stay as they were.
- R4: Each byte leaves as two halves. Bits 3:0 go first and bits 7:4 go second.
- R5: Within a half, bit 0 drives `err_line`, bit 1 drives `sel_line`, bit 2 drives `paper_line` and bit 3 drives `busy_line`.
- R6: `host_req_n` passes through a SYNC_STAGES-flop synchronizer. The status pins take the next half one cycle after the synchronized request is seen low while a byte is held.
- R7: `periph_ack_n` falls SETUP_CYC cycles after the status pins are updated. The pins stay stable while `periph_ack_n` is low.
- R8: `periph_ack_n` returns to 1 one cycle after the synchronized request is seen high.
- R9: `buf_empty` rises on the same edge at which `periph_ack_n` is released for the second half, never after the first half.
- R10: When `mode` leaves 4, `periph_ack_n` goes to 1 on the next edge. The held byte is kept, and the transfer restarts from the lower half when the mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | MODE_W | Transfer mode select; 4 enables this block |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| host_req_n | input | 1 | Host request, active low, asynchronous |
| periph_ack_n | output | 1 | Peripheral acknowledge, active low |
| err_line | output | 1 | Status pin carrying half bit 0 |
| sel_line | output | 1 | Status pin carrying half bit 1 |
| paper_line | output | 1 | Status pin carrying half bit 2 |
| busy_line | output | 1 | Status pin carrying half bit 3 |
| buf_empty | output | 1 | Holding register empty, usable as DMA request |

## Verification
The byte 0xA5 has different halves, so it shows whether the halves go out in the right order. The single-bit bytes 0x21 and 0x84 each light exactly one pin, which shows whether the pin mapping is right. The all-zero byte, the all-one byte and a spread of computed bytes are each sent with different host idle gaps, so the setup count and the synchronizer delay are tried against slow and fast hosts. Writes made while the register is full, writes made with the mode off, and a mode drop in the middle of a half tell ignored stimulus apart from accepted stimulus, and show that the transfer restarts cleanly.

// File: rtl/nib_tx_pkg.sv
// Shared constants and types for the nibble reverse transmitter.
// Assumes a byte is always split into two equal halves.
package nib_tx_pkg;
    localparam int BYTE_W     = 8;
    localparam int NIB_W      = BYTE_W / 2;
    // Position of each status pin inside a half
    localparam int LINE_ERR   = 0;
    localparam int LINE_SEL   = 1;
    localparam int LINE_PAPER = 2;
    localparam int LINE_BUSY  = 3;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_SETUP = 2'd1,
        HS_HOLD  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/nib_req_sync.sv
// Multi-flop synchronizer for the asynchronous host request line.
// Assumes STAGES >= 2. Resets to the idle (high) level.
module nib_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sr;

    // Shift the raw input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], async_in};
    end

    assign sync_out = sr[STAGES-1];
endmodule

// File: rtl/nib_hold_reg.sv
// Byte holding register with an empty flag.
// Loads only when empty and enabled. It is emptied by the handshake
// controller once the second half has been delivered.
module nib_hold_reg
    import nib_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_ok,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              byte_done,
    input  logic              half_sel,
    output logic              buf_empty,
    output logic [BYTE_W-1:0] hold_q,
    output logic [NIB_W-1:0]  nib_out
);
    // Track fill state and capture accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_empty <= 1'b1;
            hold_q    <= '0;
        end else if (byte_done) begin
            buf_empty <= 1'b1;
        end else if (wr_en && buf_empty && load_ok) begin
            buf_empty <= 1'b0;
            hold_q    <= wr_data;
        end
    end

    // Pick the half that is currently due
    always_comb begin
        if (half_sel) nib_out = hold_q[BYTE_W-1 -: NIB_W];
        else          nib_out = hold_q[NIB_W-1:0];
    end
endmodule

// File: rtl/nib_hs_fsm.sv
// Per-half interlocked handshake controller.
// Assumes req_s is already synchronized and SETUP_CYC >= 1.
// Sequence for each half: wait for the request to go low, drive the
// lines, count the setup delay, drive ack low, wait for the request
// to go high, then release ack.
module nib_hs_fsm
    import nib_tx_pkg::*;
#(
    parameter int SETUP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             have_byte,
    input  logic             req_s,
    input  logic [NIB_W-1:0] nib_in,
    output logic             ack_n,
    output logic [NIB_W-1:0] lines,
    output logic             half_sel,
    output logic             byte_done
);
    localparam int CNT_W = $clog2(SETUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETUP_CYC - 1);

    hs_state_e        state;
    logic [CNT_W-1:0] cnt;

    // Second half released by the host: the byte is finished
    assign byte_done = active && (state == HS_HOLD) && req_s && half_sel;

    // Handshake sequencing and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            cnt      <= '0;
            ack_n    <= 1'b1;
            lines    <= '0;
            half_sel <= 1'b0;
        end else if (!active) begin
            state    <= HS_IDLE;
            cnt      <= '0;
            ack_n    <= 1'b1;
            half_sel <= 1'b0;
        end else begin
            case (state)
                HS_IDLE: begin
                    if (have_byte && !req_s) begin
                        lines <= nib_in;
                        cnt   <= '0;
                        state <= HS_SETUP;
                    end
                end
                HS_SETUP: begin
                    if (cnt == CNT_LAST) begin
                        ack_n <= 1'b0;
                        state <= HS_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                HS_HOLD: begin
                    if (req_s) begin
                        ack_n    <= 1'b1;
                        half_sel <= ~half_sel;
                        state    <= HS_IDLE;
                    end
                end
                default: state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nib_rev_tx.sv
// Top of the nibble reverse transmitter.
// Assumes mode is stable relative to clk and host_req_n is asynchronous.
// Connects the synchronizer, the holding register and the handshake
// controller, and maps a half onto the four status pins.
module nib_rev_tx
    import nib_tx_pkg::*;
#(
    parameter int MODE_W      = 3,
    parameter int MODE_NIBBLE = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              host_req_n,
    output logic              periph_ack_n,
    output logic              err_line,
    output logic              sel_line,
    output logic              paper_line,
    output logic              busy_line,
    output logic              buf_empty
);
    logic              mode_act;
    logic              req_s;
    logic              byte_done;
    logic              half_sel;
    logic [NIB_W-1:0]  nib_cur;
    logic [NIB_W-1:0]  lines;
    logic [BYTE_W-1:0] hold_q;

    // Block is live only in the nibble mode
    assign mode_act = (mode == MODE_W'(MODE_NIBBLE));

    nib_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (host_req_n),
        .sync_out (req_s)
    );

    nib_hold_reg u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_ok   (mode_act),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .byte_done (byte_done),
        .half_sel  (half_sel),
        .buf_empty (buf_empty),
        .hold_q    (hold_q),
        .nib_out   (nib_cur)
    );

    nib_hs_fsm #(.SETUP_CYC(SETUP_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_act),
        .have_byte (!buf_empty),
        .req_s     (req_s),
        .nib_in    (nib_cur),
        .ack_n     (periph_ack_n),
        .lines     (lines),
        .half_sel  (half_sel),
        .byte_done (byte_done)
    );

    // Status pin mapping
    assign err_line   = lines[LINE_ERR];
    assign sel_line   = lines[LINE_SEL];
    assign paper_line = lines[LINE_PAPER];
    assign busy_line  = lines[LINE_BUSY];
endmodule

// File: rtl/nib_rev_tx_chk.sv
// Protocol checker for nib_rev_tx, attached with bind.
module nib_rev_tx_chk
    import nib_tx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mode_act,
    input logic              wr_en,
    input logic              buf_empty,
    input logic [BYTE_W-1:0] hold_q,
    input logic              periph_ack_n,
    input logic [NIB_W-1:0]  stat
);
    assert_accept_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && buf_empty && mode_act) |=> !buf_empty);

    assert_full_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !buf_empty) |=> $stable(hold_q));

    assert_lines_stable_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_ack_n) |=> $stable(stat));

    assert_empty_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> $rose(periph_ack_n));

    assert_mode_off_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_act) |=> periph_ack_n);
endmodule

bind nib_rev_tx nib_rev_tx_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_act     (mode_act),
    .wr_en        (wr_en),
    .buf_empty    (buf_empty),
    .hold_q       (hold_q),
    .periph_ack_n (periph_ack_n),
    .stat         ({busy_line, paper_line, sel_line, err_line})
);

// File: tb/nib_rev_tx_bench.sv
`timescale 1ns/1ps
module nib_rev_tx_bench;
    localparam int SYNC  = 2;
    localparam int SETUP = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       host_req_n;
    logic       periph_ack_n, err_line, sel_line, paper_line, busy_line, buf_empty;

    int vectors = 0;
    int miss    = 0;
    bit ended   = 0;

    always #2.5 clk = ~clk;

    nib_rev_tx #(.SYNC_STAGES(SYNC), .SETUP_CYC(SETUP)) u_nib_rev_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
        .host_req_n(host_req_n), .periph_ack_n(periph_ack_n), .err_line(err_line),
        .sel_line(sel_line), .paper_line(paper_line), .busy_line(busy_line),
        .buf_empty(buf_empty)
    );

    // Behavioural reference model
    bit       m_empty, m_ack, m_half;
    bit [3:0] m_stat;
    bit [7:0] m_byte;
    int       m_phase, m_cnt;
    bit       reqq[$];

    always @(posedge clk) begin : model
        bit s, act, dn;
        if (!rst_n) begin
            m_empty <= 1; m_ack <= 1; m_stat <= 0; m_half <= 0;
            m_phase <= 0; m_cnt <= 0; m_byte <= 0;
            reqq.delete();
            for (int i = 0; i < SYNC; i++) reqq.push_back(1'b1);
        end else begin
            s   = reqq[SYNC-1];
            act = (mode == 3'd4);
            dn  = 0;
            if (!act) begin
                m_phase <= 0; m_ack <= 1; m_half <= 0;
            end else if (m_phase == 0) begin
                if (!m_empty && !s) begin
                    m_stat  <= m_half ? m_byte[7:4] : m_byte[3:0];
                    m_phase <= 1; m_cnt <= 1;
                end
            end else if (m_phase == 1) begin
                if (m_cnt == SETUP) begin m_ack <= 0; m_phase <= 2; end
                else m_cnt <= m_cnt + 1;
            end else begin
                if (s) begin
                    m_ack <= 1; m_phase <= 0;
                    if (m_half) begin m_half <= 0; dn = 1; end
                    else m_half <= 1;
                end
            end
            if (dn) m_empty <= 1;
            else if (wr_en && m_empty && act) begin m_empty <= 0; m_byte <= wr_data; end
            reqq.push_front(host_req_n);
            void'(reqq.pop_back());
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare against the model every cycle
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk("R7 R8 R10 ack vs model", {7'd0, periph_ack_n}, {7'd0, m_ack});
            chk("R4 R5 R6 status vs model",
                {4'd0, busy_line, paper_line, sel_line, err_line}, {4'd0, m_stat});
            chk("R2 R9 empty vs model", {7'd0, buf_empty}, {7'd0, m_empty});
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        miss++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        finish_run();
    end

    task automatic write_byte(input logic [7:0] d);
        @(posedge clk); #1 wr_en = 1; wr_data = d;
        @(posedge clk); #1 wr_en = 0;
    endtask

    task automatic host_nibble(input int gap, output logic [3:0] got);
        repeat (gap) @(posedge clk);
        @(posedge clk); #1 host_req_n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!periph_ack_n) break;
        end
        got = {busy_line, paper_line, sel_line, err_line};
        @(posedge clk); #1 host_req_n = 1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (periph_ack_n) break;
        end
    endtask

    task automatic host_byte(input int gap, output logic [7:0] got);
        logic [3:0] lo, hi;
        host_nibble(gap, lo);
        host_nibble(gap, hi);
        got = {hi, lo};
    endtask

    initial begin
        logic [3:0] n;
        logic [7:0] b;
        rst_n = 0; host_req_n = 1; mode = 0; wr_en = 0; wr_data = 0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk("R1 reset ack", {7'd0, periph_ack_n}, 8'd1);
        chk("R1 reset status", {4'd0, busy_line, paper_line, sel_line, err_line}, 8'd0);
        chk("R1 reset empty", {7'd0, buf_empty}, 8'd1);

        // Order of halves
        @(posedge clk); #1 mode = 3'd4;
        write_byte(8'hA5);
        @(negedge clk);
        chk("R2 write accepted", {7'd0, buf_empty}, 8'd0);
        host_nibble(0, n);
        chk("R4 low half first", {4'd0, n}, 8'h05);
        chk("R9 not empty after first half", {7'd0, buf_empty}, 8'd0);
        host_nibble(2, n);
        chk("R4 high half second", {4'd0, n}, 8'h0A);
        chk("R9 empty after second half", {7'd0, buf_empty}, 8'd1);

        // Write while full is ignored
        write_byte(8'h3C);
        write_byte(8'hC3);
        host_byte(1, b);
        chk("R3 write while full ignored", b, 8'h3C);

        // Write with mode off is ignored
        @(posedge clk); #1 mode = 3'd0;
        write_byte(8'h55);
        @(negedge clk);
        chk("R3 write with mode off ignored", {7'd0, buf_empty}, 8'd1);
        @(posedge clk); #1 mode = 3'd4;

        // Pin mapping with single-bit values
        write_byte(8'h21);
        host_nibble(0, n);
        chk("R5 bit0 on err_line", {4'd0, n}, 8'h01);
        host_nibble(0, n);
        chk("R5 bit1 on sel_line", {4'd0, n}, 8'h02);
        write_byte(8'h84);
        host_nibble(3, n);
        chk("R5 bit2 on paper_line", {4'd0, n}, 8'h04);
        host_nibble(3, n);
        chk("R5 bit3 on busy_line", {4'd0, n}, 8'h08);

        // Mode drop in the middle of a half
        write_byte(8'h96);
        @(posedge clk); #1 host_req_n = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (!periph_ack_n) break;
        end
        @(posedge clk); #1 mode = 3'd0;
        repeat (3) @(negedge clk);
        chk("R10 ack released on mode exit", {7'd0, periph_ack_n}, 8'd1);
        chk("R10 byte kept on mode exit", {7'd0, buf_empty}, 8'd0);
        @(posedge clk); #1 host_req_n = 1;
        repeat (4) @(posedge clk);
        #1 mode = 3'd4;
        host_byte(0, b);
        chk("R10 restart from low half", b, 8'h96);

        // Spread of patterns with varied host pacing (R6 R7 timing via model)
        for (int i = 0; i < 10; i++) begin
            logic [7:0] v;
            v = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 37 + 11) ^ (i << 4));
            write_byte(v);
            host_byte(i % 4, b);
            chk("R4 R6 R7 pattern byte", b, v);
        end

        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule